// File: doc/BRIEF.md
# Radiation-tolerant serial command decoder

The block sits at the control input of a pixel front-end chip and turns a one-bit-per-clock command line into decoded actions. The line idles low. A command starts with the first high bit, which is also the first bit of a 5-bit head field. Fields are sent most significant bit first. The head either is a level-1 trigger or opens a longer command. The second field of a longer command picks a fast command (bunch counter reset, event counter reset, calibration pulse) or marks a slow command. A slow command then carries an operation code, a chip address and, depending on the operation, a register address, register data or a long run of configuration bits. These are passed on one per clock to the pixel shift chain.

Triggers and fast commands take effect only in run mode. Slow commands take effect at any time, but only when the chip address field matches this chip or is a broadcast. Bits of a non-matching command are still consumed so that the decoder stays in step with the line.

Every flip-flop is held in three copies. Each copy is reloaded every clock from the majority of the three, so a single upset is masked and then overwritten on the next edge. Any disagreement between the copies is counted. Malformed fields drop the decoder back to idle and are counted per field position. The decoder needs no reset between commands.

Top module: `tmr_cmd_decoder`

## Requirements
- R1: After reset every strobe output, `glob_pulse`, `run_mode`, `reg_addr`, `wr_data` and all counters are zero.
- R2: In run mode the head field 11101 raises `trig` for one cycle, one cycle after its fifth bit is sampled. Triggers sent back to back, one every 5 clocks, each produce a strobe.
- R3: In run mode a head field that differs from 11101 in exactly one of its last four bits (11111, 11001, 10101, 11100) still raises `trig`, and raises `trig_flip` in the same cycle.
- R4: Outside run mode, triggers and fast commands produce no strobe at all.
- R5: The head 10110 followed by the kind field 0001, 0010 or 0100 raises `bcr`, `ecr` or `cal` respectively, for one cycle, one cycle after the last kind bit.
- R6: Kind field 1000 marks a slow command whose 4-bit operation code follows. Operation 1010 sets `run_mode`, and `run_mode` stays set until operation 1000 (global reset). Global reset raises `glob_rst` for one cycle and clears `run_mode`.
- R7: The 4-bit chip field after the operation code matches when its MSB is 1 (broadcast) or when its low three bits equal `chip_id`. A slow command with a non-matching chip field consumes its bits and changes no output, including `reg_addr` and `wr_data`.
- R8: Operation 0010 (register write) takes a 6-bit address and then 16 data bits. It raises `wr_req` one cycle after the last data bit, with `reg_addr` and `wr_data` holding them. Operation 0001 (register read) takes only the 6-bit address and raises `rd_req` with `reg_addr`.
- R9: Operation 0100 (configuration write) takes 672 bits. Each bit appears on `fe_bit`, with `fe_shift` high, one cycle after it is sampled.
- R10: Operation 1001 (global pulse) holds `glob_pulse` high for `pulse_len`+1 cycles, starting one cycle after the last chip-field bit.
- R11: A head that is neither trigger-like nor 10110 increments `err_head`. A kind field outside {0001, 0010, 0100, 1000} increments `err_kind`. An operation code outside {0001, 0010, 0100, 1000, 1001, 1010} increments `err_op`. Each of these counters saturates at 15, and the decoder is idle on the next cycle.
- R12: A single corrupted copy of the state changes no output. Each cycle in which the three copies disagree increments `flip_cnt`, which saturates at 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_in | input | 1 | Serial command bit, sampled each rising edge |
| chip_id | input | 3 | Address of this chip |
| pulse_len | input | 6 | Global pulse length minus one |
| trig | output | 1 | Trigger strobe |
| trig_flip | output | 1 | Trigger accepted with one corrected bit |
| bcr | output | 1 | Bunch counter reset strobe |
| ecr | output | 1 | Event counter reset strobe |
| cal | output | 1 | Calibration pulse request strobe |
| rd_req | output | 1 | Register read strobe |
| wr_req | output | 1 | Register write strobe |
| reg_addr | output | 6 | Register address of the last accepted read or write |
| wr_data | output | 16 | Data of the last accepted write |
| fe_shift | output | 1 | Configuration bit valid |
| fe_bit | output | 1 | Configuration bit |
| glob_rst | output | 1 | Global reset strobe |
| glob_pulse | output | 1 | Global pulse level |
| run_mode | output | 1 | Run mode flag |
| flip_cnt | output | 5 | Copy-disagreement counter |
| err_head | output | 4 | Invalid head field counter |
| err_kind | output | 4 | Invalid kind field counter |
| err_op | output | 4 | Invalid operation code counter |

## Verification
Every strobe, as well as `reg_addr`, `wr_data` and each configuration bit, is due exactly one clock after the last bit of its field is sampled. `glob_pulse` rises in that same cycle and stays high for `pulse_len`+1 cycles. The driver stamps each expected item with that due cycle at the moment it drives the final bit. The monitor samples just after each falling edge, takes an item only when its stamp equals the current cycle, and reports any strobe that appears with no item due. Counter and `run_mode` checks are made a few idle cycles after a command, once the registered values have settled.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;

  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int FE_BITS = 672;
  localparam int ERR_W   = 4;
  localparam int FLIP_W  = 5;
  localparam int PLEN_W  = 6;
  localparam int ID_W    = 3;
  localparam int HEAD_W  = 5;
  localparam int CODE_W  = 4;
  localparam int CNT_W   = $clog2(FE_BITS + 1);
  localparam int SH_W    = DATA_W;
  localparam int GP_W    = PLEN_W + 1;

  localparam logic [HEAD_W-1:0] HEAD_TRIG = 5'b11101;
  localparam logic [HEAD_W-1:0] HEAD_CMD  = 5'b10110;

  localparam logic [CODE_W-1:0] KIND_BCR  = 4'b0001;
  localparam logic [CODE_W-1:0] KIND_ECR  = 4'b0010;
  localparam logic [CODE_W-1:0] KIND_CAL  = 4'b0100;
  localparam logic [CODE_W-1:0] KIND_SLOW = 4'b1000;

  localparam logic [CODE_W-1:0] OP_RD   = 4'b0001;
  localparam logic [CODE_W-1:0] OP_WR   = 4'b0010;
  localparam logic [CODE_W-1:0] OP_CFG  = 4'b0100;
  localparam logic [CODE_W-1:0] OP_GRST = 4'b1000;
  localparam logic [CODE_W-1:0] OP_GPLS = 4'b1001;
  localparam logic [CODE_W-1:0] OP_RUN  = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE, PH_HEAD, PH_KIND, PH_OP, PH_CHIP, PH_ADDR, PH_DATA, PH_CFG
  } phase_e;

  typedef struct packed {
    phase_e              phase;
    logic [CNT_W-1:0]    cnt;
    logic [SH_W-1:0]     shreg;
    logic [CODE_W-1:0]   op;
    logic                hit;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
    logic                run;
    logic [GP_W-1:0]     gp_cnt;
    logic [FLIP_W-1:0]   flips;
    logic [ERR_W-1:0]    e_head;
    logic [ERR_W-1:0]    e_kind;
    logic [ERR_W-1:0]    e_op;
    logic                s_trig;
    logic                s_tflip;
    logic                s_bcr;
    logic                s_ecr;
    logic                s_cal;
    logic                s_rd;
    logic                s_wr;
    logic                s_fesh;
    logic                s_febit;
    logic                s_grst;
  } cmd_state_t;

  localparam int ST_W = $bits(cmd_state_t);

  function automatic int field_len(phase_e ph);
    case (ph)
      PH_HEAD:                   return HEAD_W;
      PH_KIND, PH_OP, PH_CHIP:   return CODE_W;
      PH_ADDR:                   return ADDR_W;
      PH_DATA:                   return DATA_W;
      PH_CFG:                    return FE_BITS;
      default:                   return 1;
    endcase
  endfunction

  function automatic logic near_trig(logic [HEAD_W-1:0] f);
    return ($countones(f ^ HEAD_TRIG) <= 1);
  endfunction

  function automatic logic [ERR_W-1:0] err_inc(logic [ERR_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [FLIP_W-1:0] flip_inc(logic [FLIP_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic op_known(logic [CODE_W-1:0] c);
    return (c == OP_RD) || (c == OP_WR) || (c == OP_CFG) ||
           (c == OP_GRST) || (c == OP_GPLS) || (c == OP_RUN);
  endfunction

endpackage

// File: rtl/cmdec_vote.sv
module cmdec_vote #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] v,
  output logic         mis
);
  assign v   = (a & b) | (a & c) | (b & c);
  assign mis = (a != b) || (a != c);
endmodule

// File: rtl/cmdec_copy.sv
module cmdec_copy #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/cmdec_next.sv
module cmdec_next
  import cmdec_pkg::*;
(
  input  cmd_state_t          cur,
  input  logic                bit_in,
  input  logic [ID_W-1:0]     chip_id,
  input  logic [PLEN_W-1:0]   pulse_len,
  input  logic                mismatch,
  output cmd_state_t          nxt
);
  logic [SH_W-1:0]   sh;
  logic              at_end;
  logic              chip_hit;
  logic [CODE_W-1:0] fld4;

  assign sh       = {cur.shreg[SH_W-2:0], bit_in};
  assign at_end   = (int'(cur.cnt) == field_len(cur.phase) - 1);
  assign fld4     = sh[CODE_W-1:0];
  assign chip_hit = fld4[CODE_W-1] || (fld4[ID_W-1:0] == chip_id);

  always_comb begin
    nxt = cur;
    nxt.s_trig  = 1'b0;
    nxt.s_tflip = 1'b0;
    nxt.s_bcr   = 1'b0;
    nxt.s_ecr   = 1'b0;
    nxt.s_cal   = 1'b0;
    nxt.s_rd    = 1'b0;
    nxt.s_wr    = 1'b0;
    nxt.s_fesh  = 1'b0;
    nxt.s_febit = 1'b0;
    nxt.s_grst  = 1'b0;
    if (cur.gp_cnt != '0) nxt.gp_cnt = cur.gp_cnt - 1'b1;
    if (mismatch)         nxt.flips  = flip_inc(cur.flips);

    if (cur.phase == PH_CFG) begin
      nxt.s_fesh  = cur.hit;
      nxt.s_febit = cur.hit & bit_in;
    end

    if (cur.phase == PH_IDLE) begin
      if (bit_in) begin
        nxt.phase = PH_HEAD;
        nxt.cnt   = CNT_W'(1);
        nxt.shreg = SH_W'(1);
      end
    end else if (!at_end) begin
      nxt.shreg = sh;
      nxt.cnt   = cur.cnt + 1'b1;
    end else begin
      nxt.phase = PH_IDLE;
      nxt.cnt   = '0;
      nxt.shreg = sh;
      case (cur.phase)
        PH_HEAD: begin
          if (near_trig(sh[HEAD_W-1:0])) begin
            if (cur.run) begin
              nxt.s_trig  = 1'b1;
              nxt.s_tflip = (sh[HEAD_W-1:0] != HEAD_TRIG);
            end
          end else if (sh[HEAD_W-1:0] == HEAD_CMD) begin
            nxt.phase = PH_KIND;
          end else begin
            nxt.e_head = err_inc(cur.e_head);
          end
        end
        PH_KIND: begin
          case (fld4)
            KIND_BCR:  nxt.s_bcr = cur.run;
            KIND_ECR:  nxt.s_ecr = cur.run;
            KIND_CAL:  nxt.s_cal = cur.run;
            KIND_SLOW: nxt.phase = PH_OP;
            default:   nxt.e_kind = err_inc(cur.e_kind);
          endcase
        end
        PH_OP: begin
          if (op_known(fld4)) begin
            nxt.op    = fld4;
            nxt.phase = PH_CHIP;
          end else begin
            nxt.e_op = err_inc(cur.e_op);
          end
        end
        PH_CHIP: begin
          nxt.hit = chip_hit;
          case (cur.op)
            OP_RD, OP_WR: nxt.phase = PH_ADDR;
            OP_CFG:       nxt.phase = PH_CFG;
            OP_GRST: if (chip_hit) begin
              nxt.s_grst = 1'b1;
              nxt.run    = 1'b0;
            end
            OP_GPLS: if (chip_hit) nxt.gp_cnt = {1'b0, pulse_len} + 1'b1;
            OP_RUN:  if (chip_hit) nxt.run = 1'b1;
            default: ;
          endcase
        end
        PH_ADDR: begin
          if (cur.hit) nxt.addr = sh[ADDR_W-1:0];
          if (cur.op == OP_RD) nxt.s_rd  = cur.hit;
          else                 nxt.phase = PH_DATA;
        end
        PH_DATA: begin
          if (cur.hit) begin
            nxt.data = sh[DATA_W-1:0];
            nxt.s_wr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmr_cmd_decoder.sv
module tmr_cmd_decoder
  import cmdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_in,
  input  logic [ID_W-1:0]      chip_id,
  input  logic [PLEN_W-1:0]    pulse_len,
  output logic                 trig,
  output logic                 trig_flip,
  output logic                 bcr,
  output logic                 ecr,
  output logic                 cal,
  output logic                 rd_req,
  output logic                 wr_req,
  output logic [ADDR_W-1:0]    reg_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 fe_shift,
  output logic                 fe_bit,
  output logic                 glob_rst,
  output logic                 glob_pulse,
  output logic                 run_mode,
  output logic [FLIP_W-1:0]    flip_cnt,
  output logic [ERR_W-1:0]     err_head,
  output logic [ERR_W-1:0]     err_kind,
  output logic [ERR_W-1:0]     err_op
);
  localparam int NCOPY = 3;

  logic [ST_W-1:0] cur_q [NCOPY];
  logic [ST_W-1:0] nxt_v [NCOPY];
  logic [ST_W-1:0] voted_v;
  logic            mismatch;
  cmd_state_t      voted;

  cmdec_vote #(.W(ST_W)) u_vote (
    .a(cur_q[0]), .b(cur_q[1]), .c(cur_q[2]), .v(voted_v), .mis(mismatch)
  );
  assign voted = cmd_state_t'(voted_v);

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    cmd_state_t nxt_s;
    cmdec_next u_next (
      .cur(voted), .bit_in(cmd_in), .chip_id(chip_id),
      .pulse_len(pulse_len), .mismatch(mismatch), .nxt(nxt_s)
    );
    assign nxt_v[k] = nxt_s;
    cmdec_copy #(.W(ST_W)) u_copy (
      .clk(clk), .rst_n(rst_n), .d(nxt_v[k]), .q(cur_q[k])
    );
  end

  assign trig       = voted.s_trig;
  assign trig_flip  = voted.s_tflip;
  assign bcr        = voted.s_bcr;
  assign ecr        = voted.s_ecr;
  assign cal        = voted.s_cal;
  assign rd_req     = voted.s_rd;
  assign wr_req     = voted.s_wr;
  assign reg_addr   = voted.addr;
  assign wr_data    = voted.data;
  assign fe_shift   = voted.s_fesh;
  assign fe_bit     = voted.s_febit;
  assign glob_rst   = voted.s_grst;
  assign glob_pulse = (voted.gp_cnt != '0);
  assign run_mode   = voted.run;
  assign flip_cnt   = voted.flips;
  assign err_head   = voted.e_head;
  assign err_kind   = voted.e_kind;
  assign err_op     = voted.e_op;
endmodule

// File: rtl/tmr_cmd_decoder_chk.sv
module tmr_cmd_decoder_chk
  import cmdec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mismatch,
  input logic              trig,
  input logic              trig_flip,
  input logic              bcr,
  input logic              ecr,
  input logic              cal,
  input logic              rd_req,
  input logic              wr_req,
  input logic              fe_shift,
  input logic              fe_bit,
  input logic              glob_rst,
  input logic              run_mode,
  input logic [FLIP_W-1:0] flip_cnt
);
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig, bcr, ecr, cal, rd_req, wr_req, fe_shift, glob_rst}));

  a_r2_trig_gap: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r3_flip_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    trig_flip |-> trig);

  a_r4_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (trig || bcr || ecr || cal) |-> run_mode);

  a_r6_run_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_mode) |-> glob_rst);

  a_r9_bit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fe_bit |-> fe_shift);

  a_r12_quiet_count: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |=> $stable(flip_cnt));
endmodule

bind tmr_cmd_decoder tmr_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .trig(trig),
  .trig_flip(trig_flip), .bcr(bcr), .ecr(ecr), .cal(cal),
  .rd_req(rd_req), .wr_req(wr_req), .fe_shift(fe_shift), .fe_bit(fe_bit),
  .glob_rst(glob_rst), .run_mode(run_mode), .flip_cnt(flip_cnt)
);

// File: tb/test_tmr_cmd_decoder.sv
module test_tmr_cmd_decoder;
  localparam int PERIOD = 10;
  localparam int CFG_N  = 672;
  localparam int SW     = $bits(cmdec_pkg::cmd_state_t);

  localparam int K_TRIG = 0, K_TFLIP = 1, K_BCR = 2, K_ECR = 3, K_CAL = 4,
                 K_RD = 5, K_WR = 6, K_CFG = 7, K_GRST = 8, K_GP = 9;

  typedef struct {
    int    kind;
    int    a;
    int    d;
    int    due;
    string req;
  } exp_t;

  logic clk = 0, rst_n = 0, cmd_in = 0;
  logic [2:0] chip_id = 3'd3;
  logic [5:0] pulse_len = 6'd0;
  logic trig, trig_flip, bcr, ecr, cal, rd_req, wr_req, fe_shift, fe_bit;
  logic glob_rst, glob_pulse, run_mode;
  logic [5:0] reg_addr;
  logic [15:0] wr_data;
  logic [4:0] flip_cnt;
  logic [3:0] err_head, err_kind, err_op;

  int   cyc = 0, nchk = 0, nerr = 0, gp_left = 0;
  bit   done = 0;
  exp_t q[$];

  tmr_cmd_decoder i_tmr_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .chip_id(chip_id),
    .pulse_len(pulse_len), .trig(trig), .trig_flip(trig_flip), .bcr(bcr),
    .ecr(ecr), .cal(cal), .rd_req(rd_req), .wr_req(wr_req),
    .reg_addr(reg_addr), .wr_data(wr_data), .fe_shift(fe_shift),
    .fe_bit(fe_bit), .glob_rst(glob_rst), .glob_pulse(glob_pulse),
    .run_mode(run_mode), .flip_cnt(flip_cnt), .err_head(err_head),
    .err_kind(err_kind), .err_op(err_op)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic fail(string req, string what, longint act, longint exp);
    nerr++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    nchk++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    cmd_in = b;
  endtask

  task automatic send(int v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic expect_item(int kind, int a, int d, string req);
    exp_t it;
    it.kind = kind; it.a = a; it.d = d; it.due = cyc + 1; it.req = req;
    q.push_back(it);
  endtask

  task automatic slow(int op, int chip);
    send(5'b10110, 5); send(4'b1000, 4); send(op, 4); send(chip, 4);
  endtask

  task automatic inject_flip();
    logic [SW-1:0] v;
    @(negedge clk);
    v = i_tmr_cmd_decoder.g_copy[1].u_copy.q_r;
    force i_tmr_cmd_decoder.g_copy[1].u_copy.q_r = v ^ SW'(1);
    #1;
    release i_tmr_cmd_decoder.g_copy[1].u_copy.q_r;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      logic [9:0] ev, act;
      exp_t it;
      bit has, gexp;
      @(negedge clk);
      #1;
      ev = '0; has = 0;
      if (q.size() > 0 && q[0].due < cyc) begin
        it = q.pop_front();
        fail(it.req, "missed event", 0, it.kind);
      end
      if (q.size() > 0 && q[0].due == cyc) begin
        it = q.pop_front();
        has = 1;
        case (it.kind)
          K_TRIG:  ev[9] = 1'b1;
          K_TFLIP: ev[9:8] = 2'b11;
          K_BCR:   ev[7] = 1'b1;
          K_ECR:   ev[6] = 1'b1;
          K_CAL:   ev[5] = 1'b1;
          K_RD:    ev[4] = 1'b1;
          K_WR:    ev[3] = 1'b1;
          K_CFG:   begin ev[2] = 1'b1; ev[1] = it.d[0]; end
          K_GRST:  ev[0] = 1'b1;
          K_GP:    gp_left = it.d + 1;
          default: ;
        endcase
      end
      gexp = (gp_left > 0);
      if (gp_left > 0) gp_left--;
      act = {trig, trig_flip, bcr, ecr, cal, rd_req, wr_req, fe_shift, fe_bit, glob_rst};
      if (has || act != 0) begin
        nchk++;
        if (act != ev) fail(has ? it.req : "R4 R7", "strobes", act, ev);
        if (has && (it.kind == K_RD || it.kind == K_WR)) begin
          nchk++;
          if (reg_addr != it.a[5:0]) fail(it.req, "reg_addr", reg_addr, it.a);
        end
        if (has && it.kind == K_WR) begin
          nchk++;
          if (wr_data != it.d[15:0]) fail(it.req, "wr_data", wr_data, it.d);
        end
      end
      if (gexp || glob_pulse) begin
        nchk++;
        if (glob_pulse != gexp) fail("R10", "glob_pulse", glob_pulse, gexp);
      end
    end
  end

  // Watchdog
  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "strobes at reset", {trig, bcr, ecr, cal, rd_req, wr_req, fe_shift, glob_rst, glob_pulse}, 0);
    chk("R1", "run_mode at reset", run_mode, 0);
    chk("R1", "counters at reset", {flip_cnt, err_head, err_kind, err_op}, 0);
    chk("R1", "addr/data at reset", {reg_addr, wr_data}, 0);
    rst_n = 1;
    idle(3);

    // R4: trigger and fast commands ignored before run mode
    send(5'b11101, 5); idle(1);
    send(5'b10110, 5); send(4'b0001, 4); idle(1);
    send(5'b10110, 5); send(4'b0100, 4); idle(2);
    chk("R4", "run_mode still off", run_mode, 0);

    // R6: enter run mode by broadcast
    slow(4'b1010, 4'b1000); idle(2);
    chk("R6", "run_mode set", run_mode, 1);

    // R2: back-to-back triggers
    for (int i = 0; i < 3; i++) begin
      send(5'b11101, 5); expect_item(K_TRIG, 0, 0, "R2");
    end
    idle(2);

    // R3: single-bit-corrected triggers
    send(5'b11111, 5); expect_item(K_TFLIP, 0, 0, "R3");
    send(5'b11001, 5); expect_item(K_TFLIP, 0, 0, "R3");
    send(5'b10101, 5); expect_item(K_TFLIP, 0, 0, "R3");
    send(5'b11100, 5); expect_item(K_TFLIP, 0, 0, "R3");
    idle(2);

    // R5: fast commands
    send(5'b10110, 5); send(4'b0001, 4); expect_item(K_BCR, 0, 0, "R5");
    send(5'b10110, 5); send(4'b0010, 4); expect_item(K_ECR, 0, 0, "R5");
    send(5'b10110, 5); send(4'b0100, 4); expect_item(K_CAL, 0, 0, "R5");
    idle(2);

    // R8: register write and read to own chip
    slow(4'b0010, 4'b0011); send(6'h2A, 6); send(16'hBEEF, 16);
    expect_item(K_WR, 6'h2A, 16'hBEEF, "R8");
    idle(1);
    slow(4'b0001, 4'b1010); send(6'h15, 6);
    expect_item(K_RD, 6'h15, 0, "R8");
    idle(2);

    // R7: other chip, no broadcast: nothing changes
    slow(4'b0010, 4'b0101); send(6'h07, 6); send(16'h1234, 16);
    slow(4'b1010, 4'b0110);
    slow(4'b1000, 4'b0010);
    idle(2);
    chk("R7", "reg_addr kept", reg_addr, 6'h15);
    chk("R7", "wr_data kept", wr_data, 16'hBEEF);
    chk("R7", "run_mode kept", run_mode, 1);

    // R9: configuration write, broadcast
    slow(4'b0100, 4'b1111);
    for (int i = 0; i < CFG_N; i++) begin
      logic b;
      b = ((i * 7) % 3 == 0) ^ i[4];
      send_bit(b);
      expect_item(K_CFG, 0, int'(b), "R9");
    end
    idle(2);

    // R10: global pulse lengths
    pulse_len = 6'd5;
    slow(4'b1001, 4'b0011); expect_item(K_GP, 0, 5, "R10");
    idle(10);
    pulse_len = 6'd0;
    slow(4'b1001, 4'b1000); expect_item(K_GP, 0, 0, "R10");
    idle(4);

    // R11: invalid fields per position, then recovery
    send(5'b11000, 5); idle(2);
    chk("R11", "err_head", err_head, 1);
    send(5'b10110, 5); send(4'b0011, 4); idle(2);
    chk("R11", "err_kind", err_kind, 1);
    send(5'b10110, 5); send(4'b1000, 4); send(4'b0111, 4); idle(2);
    chk("R11", "err_op", err_op, 1);
    send(5'b11101, 5); expect_item(K_TRIG, 0, 0, "R11");
    idle(1);
    for (int i = 0; i < 20; i++) send(5'b11000, 5);
    idle(2);
    chk("R11", "err_head saturates", err_head, 15);

    // R6: global reset leaves run mode; triggers then ignored
    slow(4'b1000, 4'b0011); expect_item(K_GRST, 0, 0, "R6");
    idle(2);
    chk("R6", "run_mode cleared", run_mode, 0);
    send(5'b11101, 5); idle(2);

    // R12: single-copy corruption masked and counted
    chk("R12", "flip_cnt before", flip_cnt, 0);
    inject_flip();
    idle(3);
    chk("R12", "flip_cnt one upset", flip_cnt, 1);
    chk("R12", "run_mode unaffected", run_mode, 0);
    for (int i = 0; i < 35; i++) begin
      inject_flip();
      idle(1);
    end
    idle(2);
    chk("R12", "flip_cnt saturates", flip_cnt, 31);

    idle(5);
    chk("R2", "scoreboard drained", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule